// File: doc/BRIEF.md
# PHY Management Front End with Embedded PHY Register File

This block lets a host manage a small PHY model through a station-management style front end. The host loads three registers through a simple write port: an address register (target PHY number and PHY register number), a transmit-data register, and a command register. Command bits start a PHY register write or a PHY register read. A scan bit makes the link-fail flag follow link changes. The PHY model holds sixteen 16-bit registers. It answers at one PHY number only and reflects an external link input in its status and link-partner registers.

Every command completes at the clock edge that samples it. Read data and the link-fail flag are registered outputs, so they are valid from the cycle after that edge. No serial management timing is modelled.

Top module: `mii_mgmt_top`

## Requirements
- R1: After reset, rdData and linkFail are 0. The PHY registers hold: reg0 = 0x1000, reg1 = 0x7848, reg2 = 0x2000, reg3 = 0x5c90, reg4 = 0x01e1, and all others 0. The link is taken as down.
- R2: hostSel selects the target host register of a write. 0 is the address register, with the PHY number in bits 4:0 and the register number in bits 12:8. 1 is the command register, with bit 2 = write, bit 1 = read and bit 0 = scan (stored). 2 is transmit data. A write with hostSel = 3 has no effect.
- R3: Writing transmit data stores it. If the PHY number equals 1, the same edge also writes that value into the addressed PHY register, for registers 0 to 15 other than 1, 2 and 3.
- R4: A command with the write bit writes the stored transmit data into the addressed register. A command with the read bit loads rdData with the register value as it stands at the end of that cycle, so a write and a read in one command return the new value.
- R5: Writes to reg1, reg2 and reg3 are ignored.
- R6: A write of a word with bit 15 set to reg0 restores every PHY register to its reset value instead of storing the word.
- R7: With a PHY number other than 1, a read returns 0xffff and a write is dropped.
- R8: Register numbers 16 to 31 ignore writes, alias no lower register, and read back 0.
- R9: A link change is applied at the next edge. Going up sets reg1 bit 2 and ORs 0x01e1 into reg5. Going down clears reg1 bit 2 and ANDs reg5 with 0x01ff. A host write to reg5 in the same cycle is stored first and then adjusted.
- R10: Every read command sets linkFail to the inverse of linkUp.
- R11: While the stored scan bit is set, a link change sets linkFail to the inverse of linkUp at the next edge. With scan clear, a link change leaves linkFail unchanged.
- R12: After a soft reset the link is treated as down. If linkUp is high, the link-up effects of R9 follow one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host write strobe |
| hostSel | input | 2 | Host register select |
| hostWrData | input | 16 | Host write data |
| linkUp | input | 1 | External link state |
| rdData | output | 16 | Last PHY read result |
| linkFail | output | 1 | Link-fail flag |

## Verification
A link change and a host write to the partner register can land on the same edge. The required result is the written word, adjusted for the new link state. A soft reset and a pending link-up can also collide, and then the link-up effect must follow one edge later. The bench provokes both by changing linkUp in the same cycle as a transmit-data write, and by issuing a soft reset with the link up. Each outcome is judged by an explicit read, and by a behavioural model that is compared on every clock.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int DATA_W  = 16;
  localparam int REG_CNT = 16;
  localparam int ADDR_W  = 5;
  localparam int IDX_W   = $clog2(REG_CNT);

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_TX   = 2'd2;

  localparam int CMD_SCAN = 0;
  localparam int CMD_RD   = 1;
  localparam int CMD_WR   = 2;

  localparam int CTRL_IDX    = 0;
  localparam int STAT_IDX    = 1;
  localparam int ID_HI_IDX   = 2;
  localparam int ID_LO_IDX   = 3;
  localparam int PARTNER_IDX = 5;
  localparam int LINK_BIT    = 2;
  localparam int SOFT_RST_BIT = 15;

  localparam logic [DATA_W-1:0] PARTNER_UP_SET   = 16'h01e1;
  localparam logic [DATA_W-1:0] PARTNER_DOWN_KEEP = 16'h01ff;

  typedef struct packed {
    logic              phyWr;
    logic              phyRd;
    logic              phyHit;
    logic [ADDR_W-1:0] regAddr;
    logic [DATA_W-1:0] wrData;
    logic              scanOn;
  } mgmt_strobe_t;

  function automatic logic [DATA_W-1:0] resetValue(input int idx);
    case (idx)
      0:       return 16'h1000;
      1:       return 16'h7848;
      2:       return 16'h2000;
      3:       return 16'h5c90;
      4:       return 16'h01e1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mii_mgmt_ctrl.sv
module mii_mgmt_ctrl
  import mii_mgmt_pkg::*;
#(
  parameter int PHY_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWrData,
  output mgmt_strobe_t      strobe
);
  localparam logic [ADDR_W-1:0] MY_PHY = ADDR_W'(PHY_ID);

  logic [ADDR_W-1:0] phyAddr;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] txData;
  logic              scanOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyAddr <= '0;
      regAddr <= '0;
      txData  <= '0;
      scanOn  <= 1'b0;
    end else if (hostWrEn) begin
      case (hostSel)
        SEL_ADDR: begin
          phyAddr <= hostWrData[ADDR_W-1:0];
          regAddr <= hostWrData[8 +: ADDR_W];
        end
        SEL_CMD: scanOn <= hostWrData[CMD_SCAN];
        SEL_TX:  txData <= hostWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.phyHit  = (phyAddr == MY_PHY);
    strobe.regAddr = regAddr;
    strobe.scanOn  = scanOn;
    strobe.wrData  = txData;
    if (hostWrEn) begin
      case (hostSel)
        SEL_CMD: begin
          strobe.phyWr = hostWrData[CMD_WR] & strobe.phyHit;
          strobe.phyRd = hostWrData[CMD_RD];
        end
        SEL_TX: begin
          strobe.phyWr  = strobe.phyHit;
          strobe.wrData = hostWrData;
        end
        default: ;
      endcase
    end
  end

  assert_scan_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostSel == SEL_CMD) |=> (scanOn == $past(hostWrData[CMD_SCAN])));
endmodule

// File: rtl/mii_mgmt_datapath.sv
module mii_mgmt_datapath
  import mii_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mgmt_strobe_t      strobe,
  input  logic              linkUp,
  output logic [DATA_W-1:0] rdData,
  output logic              linkFail
);
  localparam logic [ADDR_W-1:0] REG_LIMIT = ADDR_W'(REG_CNT);

  logic [DATA_W-1:0] regQ    [REG_CNT];
  logic [DATA_W-1:0] regNext [REG_CNT];
  logic              linkSeen;
  logic              addrInRange;
  logic              wrHit;
  logic [IDX_W-1:0]  idx;
  logic              softRst;
  logic              linkChg;
  logic              linkApply;

  assign addrInRange = strobe.regAddr < REG_LIMIT;
  assign idx         = strobe.regAddr[IDX_W-1:0];
  assign wrHit       = strobe.phyWr && addrInRange;
  assign softRst     = wrHit && (idx == IDX_W'(CTRL_IDX)) && strobe.wrData[SOFT_RST_BIT];
  assign linkChg     = linkUp != linkSeen;
  assign linkApply   = linkChg && !softRst;

  for (genvar i = 0; i < REG_CNT; i++) begin : gRegs
    localparam logic [DATA_W-1:0] RST_VAL = resetValue(i);
    localparam logic [IDX_W-1:0]  MY_IDX  = IDX_W'(i);
    localparam bit READ_ONLY = (i == STAT_IDX) || (i == ID_HI_IDX) || (i == ID_LO_IDX);
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      nxt = q;
      if (softRst) begin
        nxt = RST_VAL;
      end else begin
        if (!READ_ONLY && wrHit && idx == MY_IDX) nxt = strobe.wrData;
        if (linkApply) begin
          if (i == STAT_IDX) nxt[LINK_BIT] = linkUp;
          if (i == PARTNER_IDX) nxt = linkUp ? (nxt | PARTNER_UP_SET) : (nxt & PARTNER_DOWN_KEEP);
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= RST_VAL;
      else       q <= nxt;
    end

    assign regQ[i]    = q;
    assign regNext[i] = nxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linkSeen <= 1'b0;
    else       linkSeen <= softRst ? 1'b0 : linkUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.phyRd) begin
      if (!strobe.phyHit)   rdData <= '1;
      else if (addrInRange) rdData <= regNext[idx];
      else                  rdData <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      linkFail <= 1'b0;
    else if (strobe.phyRd || (strobe.scanOn && linkChg)) linkFail <= !linkUp;
  end

  assert_status_ro_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && idx == IDX_W'(STAT_IDX) && !linkChg) |=> $stable(regQ[STAT_IDX]));

  assert_link_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    linkApply |=> (regQ[STAT_IDX][LINK_BIT] == $past(linkUp)));

  assert_miss_ones_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.phyRd && !strobe.phyHit) |=> (rdData == '1));

  assert_soft_rst_R6: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (regQ[CTRL_IDX] == resetValue(CTRL_IDX)));

  assert_read_fail_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.phyRd |=> (linkFail == !$past(linkUp)));

  assert_scan_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.phyRd && !(strobe.scanOn && linkChg)) |=> $stable(linkFail));
endmodule

// File: rtl/mii_mgmt_top.sv
module mii_mgmt_top
  import mii_mgmt_pkg::*;
#(
  parameter int PHY_ID = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostSel,
  input  logic [15:0] hostWrData,
  input  logic        linkUp,
  output logic [15:0] rdData,
  output logic        linkFail
);
  mgmt_strobe_t strobe;

  mii_mgmt_ctrl #(.PHY_ID(PHY_ID)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostSel    (hostSel),
    .hostWrData (hostWrData),
    .strobe     (strobe)
  );

  mii_mgmt_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .linkUp   (linkUp),
    .rdData   (rdData),
    .linkFail (linkFail)
  );
endmodule

// File: tb/mii_mgmt_top_tb_top.sv
`timescale 1ns/1ps
module mii_mgmt_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [15:0] hostWrData = 16'h0;
  logic        linkUp = 1'b0;
  logic [15:0] rdData;
  logic        linkFail;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mii_mgmt_top dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .linkUp(linkUp), .rdData(rdData), .linkFail(linkFail)
  );

  // Behavioural reference model
  int mRegs[16];
  int mPhy, mReg, mTx, mRd;
  bit mScan, mSeen, mFail;
  int tWd, tIdx;
  bit tWr, tRd, tSoft, tChg;

  function automatic int dflt(input int i);
    case (i)
      0: return 'h1000;
      1: return 'h7848;
      2: return 'h2000;
      3: return 'h5c90;
      4: return 'h01e1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mRegs[i] = dflt(i);
      mPhy = 0; mReg = 0; mTx = 0; mRd = 0; mScan = 0; mSeen = 0; mFail = 0;
    end else begin
      tWr = 0; tRd = 0; tWd = mTx;
      if (hostWrEn && hostSel == 2'd1) begin
        tWr = hostWrData[2] && mPhy == 1;
        tRd = hostWrData[1];
      end else if (hostWrEn && hostSel == 2'd2) begin
        tWr = (mPhy == 1);
        tWd = int'(hostWrData);
      end
      tSoft = tWr && mReg == 0 && tWd[15];
      tChg = (linkUp != mSeen);
      if (tSoft) begin
        for (int i = 0; i < 16; i++) mRegs[i] = dflt(i);
      end else begin
        if (tWr && mReg < 16 && !(mReg >= 1 && mReg <= 3)) mRegs[mReg] = tWd;
        if (tChg) begin
          if (linkUp) begin
            mRegs[1] = mRegs[1] | 4;
            mRegs[5] = mRegs[5] | 'h01e1;
          end else begin
            mRegs[1] = mRegs[1] & 'hfffb;
            mRegs[5] = mRegs[5] & 'h01ff;
          end
        end
      end
      if (tRd) begin
        mRd = (mPhy != 1) ? 'hffff : (mReg < 16 ? mRegs[mReg] : 0);
        mFail = !linkUp;
      end else if (mScan && tChg) begin
        mFail = !linkUp;
      end
      mSeen = tSoft ? 1'b0 : linkUp;
      if (hostWrEn && hostSel == 2'd0) begin
        mPhy = int'(hostWrData[4:0]);
        mReg = int'(hostWrData[12:8]);
      end else if (hostWrEn && hostSel == 2'd1) begin
        mScan = hostWrData[0];
      end else if (hostWrEn && hostSel == 2'd2) begin
        mTx = int'(hostWrData);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R4 R9 model rdData", int'(rdData), mRd);
      check("R10 R11 model linkFail", int'(linkFail), int'(mFail));
    end
  end

  task automatic op(input logic [1:0] s, input logic [15:0] d);
    @(posedge clk); #1;
    hostWrEn = 1'b1; hostSel = s; hostWrData = d;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic opLink(input logic [1:0] s, input logic [15:0] d, input logic l);
    @(posedge clk); #1;
    hostWrEn = 1'b1; hostSel = s; hostWrData = d; linkUp = l;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic setLink(input logic l);
    @(posedge clk); #1; linkUp = l;
    @(posedge clk); #1;
  endtask

  task automatic readAt(input logic [15:0] addrWord, input int exp, input string tag);
    op(2'd0, addrWord);
    op(2'd1, 16'h0002);
    check(tag, int'(rdData), exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rdData", int'(rdData), 0);
    check("R1 reset linkFail", int'(linkFail), 0);
    rstN = 1'b1;

    readAt(16'h0001, 'h1000, "R1 reg0");
    readAt(16'h0101, 'h7848, "R1 reg1");
    readAt(16'h0201, 'h2000, "R1 reg2");
    readAt(16'h0301, 'h5c90, "R1 reg3");
    readAt(16'h0401, 'h01e1, "R1 reg4");
    readAt(16'h0501, 'h0000, "R1 reg5");

    op(2'd0, 16'h0401); op(2'd2, 16'h1234);
    readAt(16'h0401, 'h1234, "R3 tx write reg4");

    op(2'd0, 16'h0902); op(2'd2, 16'hbeef);
    op(2'd0, 16'h0901); op(2'd1, 16'h0006);
    check("R4 write+read reg9", int'(rdData), 'hbeef);

    op(2'd0, 16'h0101); op(2'd2, 16'hffff);
    readAt(16'h0101, 'h7848, "R5 status ignores write");
    op(2'd0, 16'h0201); op(2'd2, 16'h0000);
    readAt(16'h0201, 'h2000, "R5 id ignores write");

    readAt(16'h0903, 'hffff, "R7 other phy reads ones");
    op(2'd2, 16'h1111);
    readAt(16'h0901, 'hbeef, "R7 other phy write dropped");

    op(2'd0, 16'h1401); op(2'd2, 16'h5555);
    readAt(16'h1401, 'h0000, "R8 high reg reads zero");
    readAt(16'h0401, 'h1234, "R8 no alias into reg4");

    op(2'd3, 16'hffff);
    op(2'd1, 16'h0002);
    check("R2 sel3 no effect", int'(rdData), 'h1234);

    setLink(1'b1);
    readAt(16'h0101, 'h784c, "R9 link up status");
    check("R10 read refresh up", int'(linkFail), 0);
    readAt(16'h0501, 'h01e1, "R9 link up partner");
    op(2'd2, 16'hffff);
    setLink(1'b0);
    op(2'd1, 16'h0002);
    check("R9 link down partner mask", int'(rdData), 'h01ff);
    check("R10 read refresh down", int'(linkFail), 1);

    setLink(1'b1);
    @(posedge clk); #1;
    check("R11 scan clear holds", int'(linkFail), 1);
    op(2'd1, 16'h0001);
    setLink(1'b0);
    setLink(1'b1);
    check("R11 scan follows up", int'(linkFail), 0);
    setLink(1'b0);
    check("R11 scan follows down", int'(linkFail), 1);

    opLink(2'd2, 16'h8000, 1'b1);
    op(2'd1, 16'h0002);
    check("R9 same cycle write and link", int'(rdData), 'h81e1);

    op(2'd0, 16'h0001);
    op(2'd1, 16'h0006);
    check("R6 soft reset reg0", int'(rdData), 'h1000);
    readAt(16'h0101, 'h784c, "R12 link reapplied");
    readAt(16'h0501, 'h01e1, "R6 partner reset then up");
    readAt(16'h0901, 'h0000, "R6 reg9 cleared");
    readAt(16'h0401, 'h01e1, "R6 reg4 default");

    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule